// File: doc/BRIEF.md
# Mantissa Right Shifter with Sticky Collection

This block moves a 96-bit floating-point mantissa toward its low end by a variable number of bit positions. Every bit that leaves the low end is folded into a one-bit sticky flag, so that a later rounding step can still tell whether anything nonzero was discarded. The mantissa is carried as three 32-bit words. The most significant word sits in bits 95:64, the middle word in bits 63:32 and the least significant word in bits 31:0. Payloads of quiet or signalling NaNs are shifted in exactly the same way as ordinary numbers. Rounding, exponent correction and class handling belong to neighbouring logic.

The shift is done in two steps within one cycle. The first step drops whole words: it slides by zero, one or two word positions, and any word pushed off the end is ORed into the sticky flag. The second step then shifts by the remaining 0 to 31 bits, so that bits cross from each word into the one below it. A count that reaches the full mantissa width takes a shortcut: the mantissa becomes zero and sticky is forced to 1.

The caller presents the mantissa, its sticky flag and an 8-bit count together with a valid strobe. The result appears on registered outputs one cycle later.

Top module: `mant_rshift_sticky`

## Requirements
- R1: While reset is asserted, out_valid, out_mant and out_sticky are all zero.
- R2: A count of 0 returns in_mant unchanged and returns in_sticky as out_sticky.
- R3: A count from 32 to 63 drops the low word into sticky and moves each remaining word down one position. The leftover count (count mod 32) is then applied as a bit shift.
- R4: A count from 64 to 95 drops the two low words into sticky and moves the top word into the low word position. The top and middle words become zero before the leftover bit shift is applied.
- R5: The leftover bit shift carries the low bits of each upper word into the top of the word below it. Bits shifted out of the low word are ORed into sticky. Overall, out_mant equals in_mant shifted right by the count.
- R6: When in_sticky is 1, out_sticky is 1 for any count.
- R7: A count of 96 or more gives out_mant = 0 and out_sticky = 1, whatever the mantissa and the incoming sticky.
- R8: out_valid is high in exactly those cycles that follow a cycle with in_valid high, so each result appears one cycle after its input.
- R9: In a cycle without in_valid, out_mant and out_sticky keep their previous values.
- R10: For counts below 96, out_sticky is 0 when in_sticky is 0 and every discarded bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are to be taken this cycle |
| in_mant | input | 96 | Mantissa; bits 95:64 most significant word, 31:0 least significant |
| in_sticky | input | 1 | Sticky flag accumulated before this shift |
| in_shift | input | 8 | Right shift count in bits |
| out_valid | output | 1 | out_mant and out_sticky carry a new result |
| out_mant | output | 96 | Shifted mantissa |
| out_sticky | output | 1 | Incoming sticky ORed with every discarded bit |

## Verification
Both shift steps can discard bits for the same operation. A count such as 45, 70 or 95 removes whole words and then also removes residual bits, and both losses, together with the incoming sticky, must merge into one flag. The bench provokes this with mantissas whose nonzero discarded bits lie only in the dropped words, only in the residual span, or in neither. It judges each result against a model that shifts the mantissa as a double-width number and ORs the entire lower half. That way, a loss missed by either step shows up as a wrong sticky value.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  // Default geometry of the mantissa datapath.
  localparam int unsigned DEF_WORD_W    = 32;
  localparam int unsigned DEF_NUM_WORDS = 3;
  localparam int unsigned DEF_CNT_W     = 8;

  // How a shift count is treated.
  typedef enum logic [1:0] {
    SHR_PASS    = 2'd0,  // count is zero
    SHR_PARTIAL = 2'd1,  // some bits survive
    SHR_FLUSH   = 2'd2   // every bit leaves the field
  } shr_kind_e;

  // Classify a count against the mantissa width.
  function automatic shr_kind_e classify(input int unsigned cnt,
                                         input int unsigned mant_w);
    if (cnt == 0)            return SHR_PASS;
    else if (cnt >= mant_w)  return SHR_FLUSH;
    else                     return SHR_PARTIAL;
  endfunction

  // Whole words skipped by a count.
  function automatic int unsigned word_part(input int unsigned cnt,
                                            input int unsigned word_w);
    return cnt / word_w;
  endfunction

  // Residual bit count after the whole words.
  function automatic int unsigned bit_part(input int unsigned cnt,
                                           input int unsigned word_w);
    return cnt % word_w;
  endfunction

endpackage

// File: rtl/mrs_count_split.sv
module mrs_count_split
  import mrs_pkg::*;
#(
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned MANT_W   = WORD_W * NUM_WORDS,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned BIDX_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic [CNT_W-1:0]  shift_i,
  output shr_kind_e         kind_o,
  output logic [WIDX_W-1:0] word_idx_o,
  output logic [BIDX_W-1:0] bit_idx_o
);

  logic [31:0] cnt_ext;

  always_comb begin
    cnt_ext    = 32'(shift_i);
    kind_o     = classify(cnt_ext, MANT_W);
    word_idx_o = WIDX_W'(word_part(cnt_ext, WORD_W));
    bit_idx_o  = BIDX_W'(bit_part(cnt_ext, WORD_W));
  end

endmodule

// File: rtl/mrs_word_stage.sv
module mrs_word_stage #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  localparam int unsigned MANT_W   = WORD_W * NUM_WORDS,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [WIDX_W-1:0] word_idx_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              sticky_o,
  output logic              lost_o
);

  // One candidate per possible whole-word slide.
  logic [MANT_W-1:0]    cand [NUM_WORDS];
  logic [NUM_WORDS-1:0] cand_lost;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slide
    if (k == 0) begin : g_none
      assign cand[k]      = mant_i;
      assign cand_lost[k] = 1'b0;
    end else begin : g_some
      assign cand[k]      = {{(k*WORD_W){1'b0}}, mant_i[MANT_W-1:k*WORD_W]};
      assign cand_lost[k] = |mant_i[k*WORD_W-1:0];
    end
  end

  always_comb begin
    mant_o = mant_i;
    lost_o = 1'b0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (word_idx_i == WIDX_W'(k)) begin
        mant_o = cand[k];
        lost_o = cand_lost[k];
      end
    end
    sticky_o = sticky_i | lost_o;
  end

endmodule

// File: rtl/mrs_bit_stage.sv
module mrs_bit_stage #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MANT_W  = 96,
  localparam int unsigned BIDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [BIDX_W-1:0] bit_idx_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              sticky_o,
  output logic              lost_o
);

  // Logarithmic shifter: level j moves by 2**j when bit j of the count is set.
  logic [MANT_W-1:0] lvl [BIDX_W+1];
  logic [BIDX_W-1:0] lvl_lost;

  assign lvl[0] = mant_i;

  for (genvar j = 0; j < BIDX_W; j++) begin : g_lvl
    localparam int unsigned SH = 1 << j;
    assign lvl[j+1]    = bit_idx_i[j] ? (lvl[j] >> SH) : lvl[j];
    assign lvl_lost[j] = bit_idx_i[j] & (|lvl[j][SH-1:0]);
  end

  assign mant_o   = lvl[BIDX_W];
  assign lost_o   = |lvl_lost;
  assign sticky_o = sticky_i | lost_o;

endmodule

// File: rtl/mant_rshift_sticky.sv
module mant_rshift_sticky
  import mrs_pkg::*;
#(
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned NUM_WORDS = DEF_NUM_WORDS,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned MANT_W   = WORD_W * NUM_WORDS,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned BIDX_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [CNT_W-1:0]  in_shift,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_sticky
);

  shr_kind_e         kind;
  logic [WIDX_W-1:0] word_idx;
  logic [BIDX_W-1:0] bit_idx;

  logic [MANT_W-1:0] word_mant, bit_mant, nxt_mant;
  logic              word_sticky, bit_sticky, nxt_sticky;

  // Named events for the checks below.
  logic flush_evt;
  logic word_drop_evt;
  logic bit_drop_evt;

  mrs_count_split #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W)
  ) u_split (
    .shift_i    (in_shift),
    .kind_o     (kind),
    .word_idx_o (word_idx),
    .bit_idx_o  (bit_idx)
  );

  mrs_word_stage #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
  ) u_words (
    .mant_i     (in_mant),
    .sticky_i   (in_sticky),
    .word_idx_i (word_idx),
    .mant_o     (word_mant),
    .sticky_o   (word_sticky),
    .lost_o     (word_drop_evt)
  );

  mrs_bit_stage #(
    .WORD_W(WORD_W), .MANT_W(MANT_W)
  ) u_bits (
    .mant_i    (word_mant),
    .sticky_i  (word_sticky),
    .bit_idx_i (bit_idx),
    .mant_o    (bit_mant),
    .sticky_o  (bit_sticky),
    .lost_o    (bit_drop_evt)
  );

  assign flush_evt  = (kind == SHR_FLUSH);
  assign nxt_mant   = flush_evt ? '0   : bit_mant;
  assign nxt_sticky = flush_evt ? 1'b1 : bit_sticky;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mant   <= '0;
      out_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant   <= nxt_mant;
        out_sticky <= nxt_sticky;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mant) && $stable(out_sticky)));

  // R7
  flush_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (32'(in_shift) >= MANT_W)) |=> (out_mant == '0 && out_sticky));

  // R6
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sticky) |=> out_sticky);

  // R2
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_shift == '0) |=>
      (out_mant == $past(in_mant) && out_sticky == $past(in_sticky)));

  // R10
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sticky && !flush_evt && !word_drop_evt && !bit_drop_evt)
      |=> !out_sticky);

endmodule

// File: tb/tb_mant_rshift_sticky.sv
`timescale 1ns/1ps
module tb_mant_rshift_sticky;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [95:0] in_mant;
  logic        in_sticky;
  logic [7:0]  in_shift;
  logic        out_valid;
  logic [95:0] out_mant;
  logic        out_sticky;

  always #2.5 clk = ~clk;

  mant_rshift_sticky dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_shift(in_shift), .out_valid(out_valid),
    .out_mant(out_mant), .out_sticky(out_sticky)
  );

  typedef struct {
    logic [96:0] res;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  bit          have_last = 1'b0;
  logic [96:0] last_res;
  logic        acc_q = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [96:0] act, input logic [96:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: shift as a double-width value, everything in the low half is lost.
  function automatic logic [96:0] model(input logic [95:0] m, input logic s,
                                        input int sh);
    logic [191:0] wide;
    if (sh >= 96) return {96'b0, 1'b1};
    wide = {m, 96'b0} >> sh;
    return {wide[191:96], s | (|wide[95:0])};
  endfunction

  task automatic send(input logic [95:0] m, input logic s, input int sh,
                      input string tag);
    exp_t e;
    in_valid  = 1'b1;
    in_mant   = m;
    in_sticky = s;
    in_shift  = 8'(sh);
    e.res = model(m, s, sh);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) acc_q <= rst_n ? in_valid : 1'b0;

  // Monitor: valid timing, scoreboard comparison, hold between results.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid === acc_q, "R8", {96'b0, out_valid}, {96'b0, acc_q});
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", {out_mant, out_sticky}, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({out_mant, out_sticky} === e.res, e.tag,
                {out_mant, out_sticky}, e.res);
          last_res  = e.res;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check({out_mant, out_sticky} === last_res, "R9",
              {out_mant, out_sticky}, last_res);
      end
    end
  end

  localparam logic [95:0] PAT_A = 96'h8000_0001_F0F0_0F0F_1234_5678;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_sticky = 1'b0; in_shift = '0;
    repeat (3) @(negedge clk);
    check({out_valid, out_mant, out_sticky} === '0, "R1",
          {out_mant, out_sticky}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    send(PAT_A, 1'b0, 0,  "R2");
    send(PAT_A, 1'b1, 0,  "R2 R6");
    send(PAT_A, 1'b0, 32, "R3");
    send(PAT_A, 1'b0, 45, "R3 R5");
    send(PAT_A, 1'b0, 63, "R3 R5");
    idle(3);
    send(PAT_A, 1'b0, 64, "R4");
    send(PAT_A, 1'b0, 70, "R4 R5");
    send(PAT_A, 1'b0, 95, "R4 R5");
    idle(1);
    send(PAT_A, 1'b0, 1,  "R5");
    send(PAT_A, 1'b0, 31, "R5");
    send(96'h0000_0001_0000_0001_0000_0000, 1'b0, 1, "R5 R10");
    send(PAT_A, 1'b0, 96,  "R7");
    send('0,    1'b0, 200, "R7");
    send(PAT_A, 1'b1, 255, "R7 R6");
    idle(2);
    send(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FF00, 1'b0, 8, "R10");
    send(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FF00, 1'b0, 9, "R10 R5");
    send(96'h1234_5678_0000_0000_0000_0000, 1'b0, 64, "R4 R10");
    send(96'h1234_5678_0000_0000_0000_0000, 1'b0, 67, "R4 R10");
    send(96'h0000_0000_0000_0000_0000_0100, 1'b1, 4, "R6");
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom, $urandom}, 1'($urandom), int'($urandom % 110),
           "R5 random");
      if (i % 7 == 3) idle(1 + i % 3);
    end
    idle(4);
    check(sb.size() == 0, "R8", 97'(sb.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule